// File: doc/BRIEF.md
# Crossbar Switch with Per-Output Round-Robin Arbitration

This block connects a set of requester ports (typically processors) to a set of target ports (typically memory modules) through a full matrix of crosspoints. There is one crosspoint for each pairing of an input row with an output column, so there are N_IN × N_OUT of them. Each input presents a valid flag, a target index and a data word. In the same clock, every output column picks one of the inputs aimed at it, closes that crosspoint, and returns an accept to the chosen input.

Each column has its own arbiter. Inputs aimed at different outputs are therefore all served in the same cycle. When several inputs contend for one output, a rotating priority pointer for that column decides which one wins. An input that is not accepted keeps its request, target and data steady and tries again on the next cycle. The output side is registered: the winning word and its valid flag appear one clock after the grant. A target index equal to or above N_OUT names no output and is never accepted.

Top module: `xbar_switch`

## Requirements
- R1: An input with `in_valid` high and a target index below N_OUT requests only the output with that index. Every output that has at least one requester grants exactly one of them, and `in_accept` of the granted input is high in that same cycle.
- R2: Inputs aimed at pairwise distinct outputs are all accepted in the same cycle. For example, inputs 0,1,2,3 aimed at outputs 2,0,3,1 give `in_accept` = 4'b1111.
- R3: Each output keeps a priority pointer, and reset sets it to input 0. Candidates are scanned from the pointer upward, wrapping around, and the first one requesting wins. After a grant to input w, the pointer of that output moves to (w+1) mod N_IN.
- R4: At most one crosspoint per output column is closed in any cycle.
- R5: At most one crosspoint per input row is closed in any cycle, so an input is accepted by at most one output.
- R6: `out_valid[o]` is high in the cycle after a grant on output o, and `out_data[o]` then carries the granted input's word. If the output had no grant, `out_valid[o]` is low and `out_data[o]` keeps its previous value.
- R7: A target index of N_OUT or greater (4 to 7 in the default 3-bit field) never produces an accept. It also leaves no output valid in the following cycle.
- R8: While `rst_n` is low at a clock edge, every `out_valid` and `out_data` bit is cleared and every pointer returns to input 0.
- R9: Several inputs hold a request to one output without change. Each of them is accepted exactly once in every span of as many cycles as there are contenders, so no input starves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | N_IN | Request flag per input |
| in_dst | input | N_IN*DST_W | Target index per input; input i uses bits [i*DST_W +: DST_W] |
| in_data | input | N_IN*DATA_W | Data word per input; input i uses bits [i*DATA_W +: DATA_W] |
| in_accept | output | N_IN | High in the cycle in which the input's crosspoint is closed |
| out_valid | output | N_OUT | Registered valid per output |
| out_data | output | N_OUT*DATA_W | Registered data per output; output o uses bits [o*DATA_W +: DATA_W] |

## Verification
The 4×4 configuration is driven with every combination of valid mask and target value from 0 to 4, one pattern per cycle. The patterns include disjoint pairings, partial contention, full contention on one column and invalid targets. A bench model with its own rotating pointers checks the accepts and the registered outputs on every cycle, which separates a wrong winner from a pointer that advances wrongly. Directed runs add the other invalid codes and a permutation where every input wins at once. A long run of four inputs held on one column shows whether the rotation spreads the grants evenly or lets an input starve.

// File: rtl/xbar_pkg.sv
// Shared helpers for the crossbar switch.
// Assumes: indices are non-negative and below the count they wrap at.
package xbar_pkg;

    // Next position of a rotating pointer over n entries.
    function automatic int unsigned rr_next(input int unsigned idx, input int unsigned n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/xbar_req_dec.sv
// Request decoder: turns each input's valid flag and target index into a
// request bit in the column of the addressed output.
// Assumes: targets at or above N_OUT are invalid and raise no request.
module xbar_req_dec #(
    parameter int N_IN  = 4,
    parameter int N_OUT = 4,
    parameter int DST_W = 3
) (
    input  logic [N_IN-1:0]       in_valid,
    input  logic [N_IN*DST_W-1:0] in_dst,
    output logic [N_IN-1:0]       req_col [N_OUT]
);

    // One comparator per crosspoint: row i asks column o.
    for (genvar o = 0; o < N_OUT; o++) begin : g_col
        for (genvar i = 0; i < N_IN; i++) begin : g_row
            assign req_col[o][i] = in_valid[i] &&
                                   (in_dst[i*DST_W +: DST_W] == DST_W'(o));
        end
    end

endmodule

// File: rtl/xbar_rr_arb.sv
// Round-robin arbiter for one output column. Scans the requests starting at
// the pointer and grants the first one found. After a grant the pointer
// moves to the input after the winner.
// Assumes: synchronous active-low reset; the pointer starts at input 0.
module xbar_rr_arb #(
    parameter int N = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);

    logic [IDX_W-1:0] ptr;
    logic [IDX_W-1:0] win_idx;
    logic             any_gnt;

    // Pick the first requester at or after the pointer, wrapping around.
    always_comb begin
        gnt     = '0;
        win_idx = '0;
        any_gnt = 1'b0;
        for (int k = 0; k < N; k++) begin
            if (!any_gnt && req[(int'(ptr) + k) % N]) begin
                any_gnt                  = 1'b1;
                gnt[(int'(ptr) + k) % N] = 1'b1;
                win_idx                  = IDX_W'((int'(ptr) + k) % N);
            end
        end
    end

    // Move the pointer past the winner whenever a grant is given.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (any_gnt) begin
            ptr <= IDX_W'(xbar_pkg::rr_next(int'(win_idx), N));
        end
    end

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R4
    AST_GNT_ONLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0); // R1
    AST_REQ_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> (|gnt)); // R1
    AST_PTR_ROTATES: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt) |=> (int'(ptr) == int'(xbar_pkg::rr_next(int'($past(win_idx)), N)))); // R3

endmodule

// File: rtl/xbar_out_stage.sv
// Output column stage: selects the granted input's word and registers it
// together with a valid flag.
// Assumes: gnt is one-hot or zero; the data register holds when idle.
module xbar_out_stage #(
    parameter int N_IN   = 4,
    parameter int DATA_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_IN-1:0]        gnt,
    input  logic [N_IN*DATA_W-1:0] in_data,
    output logic                   out_valid,
    output logic [DATA_W-1:0]      out_data
);

    logic [DATA_W-1:0] sel_data;

    // AND-OR mux over the closed crosspoint of this column.
    always_comb begin
        sel_data = '0;
        for (int i = 0; i < N_IN; i++) begin
            sel_data = sel_data | (in_data[i*DATA_W +: DATA_W] & {DATA_W{gnt[i]}});
        end
    end

    // Register the valid flag every cycle; load data only when granted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= |gnt;
            if (|gnt) begin
                out_data <= sel_data;
            end
        end
    end

    AST_OUT_FOLLOWS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt) |=> out_valid); // R6
    AST_OUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(|gnt) |=> !out_valid); // R6
    AST_OUT_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(|gnt) |=> $stable(out_data)); // R6

endmodule

// File: rtl/xbar_switch.sv
// N_IN x N_OUT crossbar with one round-robin arbiter per output column.
// Each cycle every column closes at most one crosspoint. The chosen input
// sees in_accept in that cycle, and the column's output register loads its
// word for the next cycle.
// Assumes: a requester that is not accepted holds in_dst and in_data steady;
// targets at or above N_OUT are ignored.
module xbar_switch #(
    parameter int N_IN   = 4,
    parameter int N_OUT  = 4,
    parameter int DATA_W = 8,
    parameter int DST_W  = $clog2(N_OUT + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_IN-1:0]         in_valid,
    input  logic [N_IN*DST_W-1:0]   in_dst,
    input  logic [N_IN*DATA_W-1:0]  in_data,
    output logic [N_IN-1:0]         in_accept,
    output logic [N_OUT-1:0]        out_valid,
    output logic [N_OUT*DATA_W-1:0] out_data
);

    logic [N_IN-1:0]  req_col [N_OUT];
    logic [N_IN-1:0]  gnt_col [N_OUT];
    logic [N_OUT-1:0] gnt_row [N_IN];

    xbar_req_dec #(.N_IN(N_IN), .N_OUT(N_OUT), .DST_W(DST_W)) dec_i (
        .in_valid (in_valid),
        .in_dst   (in_dst),
        .req_col  (req_col)
    );

    // One arbiter and one output register per column.
    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        xbar_rr_arb #(.N(N_IN)) arb_i (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (req_col[o]),
            .gnt   (gnt_col[o])
        );

        xbar_out_stage #(.N_IN(N_IN), .DATA_W(DATA_W)) ost_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .gnt       (gnt_col[o]),
            .in_data   (in_data),
            .out_valid (out_valid[o]),
            .out_data  (out_data[o*DATA_W +: DATA_W])
        );
    end

    // Transpose the grants into rows for the accept logic and the row checks.
    for (genvar i = 0; i < N_IN; i++) begin : g_row
        for (genvar o = 0; o < N_OUT; o++) begin : g_bit
            assign gnt_row[i][o] = gnt_col[o][i];
        end

        // An input is accepted when any column closed its crosspoint.
        assign in_accept[i] = |gnt_row[i];

        AST_ROW_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(gnt_row[i]) <= 1); // R5
        AST_BAD_DST_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid[i] && (int'(in_dst[i*DST_W +: DST_W]) >= N_OUT)) |-> !in_accept[i]); // R7
        AST_ACCEPT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid[i] |-> !in_accept[i]); // R1
    end

endmodule

// File: tb/xbar_switch_tb_top.sv
`timescale 1ns/1ps
module xbar_switch_tb_top;

    localparam int NI = 4;
    localparam int NO = 4;
    localparam int DW = 8;
    localparam int SW = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NI-1:0]    in_valid = '0;
    logic [NI*SW-1:0] in_dst = '0;
    logic [NI*DW-1:0] in_data = '0;
    logic [NI-1:0]    in_accept;
    logic [NO-1:0]    out_valid;
    logic [NO*DW-1:0] out_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int seq    = 0;

    int            mptr [NO];
    logic [NO-1:0] exp_ov = '0;
    logic [DW-1:0] exp_od [NO];
    logic [NI-1:0] exp_acc;

    always #4 clk = ~clk;

    xbar_switch #(.N_IN(NI), .N_OUT(NO), .DATA_W(DW), .DST_W(SW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_dst    (in_dst),
        .in_data   (in_data),
        .in_accept (in_accept),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (seq %0d)", req, act, exp, seq);
        end
    endtask

    // Compare the registered outputs with the previous cycle's model result.
    task automatic check_outputs();
        logic [NO*DW-1:0] eod;
        for (int o = 0; o < NO; o++) eod[o*DW +: DW] = exp_od[o];
        check(out_valid == exp_ov, "R6 out_valid", 64'(out_valid), 64'(exp_ov));
        check(out_data == eod, "R6 out_data", 64'(out_data), 64'(eod));
    endtask

    // One cycle: check old outputs, drive a pattern, check accepts, step model.
    task automatic cycle(input logic [NI-1:0] vm, input int d0, input int d1,
                         input int d2, input int d3, input string rq);
        int d [NI];
        d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
        @(negedge clk);
        check_outputs();
        in_valid = vm;
        for (int i = 0; i < NI; i++) begin
            in_dst[i*SW +: SW]  = SW'(d[i]);
            in_data[i*DW +: DW] = DW'(seq * 7 + i * 53 + 1);
        end
        #1;
        exp_acc = '0;
        for (int o = 0; o < NO; o++) begin
            int w;
            w = -1;
            for (int k = 0; k < NI; k++) begin
                int c;
                c = (mptr[o] + k) % NI;
                if (w < 0 && vm[c] && d[c] == o) w = c;
            end
            exp_ov[o] = (w >= 0);
            if (w >= 0) begin
                exp_acc[w] = 1'b1;
                exp_od[o]  = DW'(seq * 7 + w * 53 + 1);
                mptr[o]    = (w + 1) % NI;
            end
        end
        check(in_accept == exp_acc, rq, 64'(in_accept), 64'(exp_acc));
        seq++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int o = 0; o < NO; o++) begin
            mptr[o] = 0;
            exp_od[o] = '0;
        end
        // R8: outputs clear under reset.
        repeat (3) @(negedge clk);
        check(out_valid == '0, "R8 out_valid", 64'(out_valid), 64'h0);
        check(out_data == '0, "R8 out_data", 64'(out_data), 64'h0);
        rst_n = 1'b1;

        // R3: after reset all contend for output 0; input 0 wins first.
        cycle(4'b1111, 0, 0, 0, 0, "R3 accept");
        check(in_accept == 4'b0001, "R3 first winner", 64'(in_accept), 64'h1);

        // R2: a permutation connects all pairs at once.
        cycle(4'b1111, 2, 0, 3, 1, "R2 accept");
        check(in_accept == 4'b1111, "R2 all accepted", 64'(in_accept), 64'hf);

        // R7: invalid target codes never accept.
        cycle(4'b1111, 4, 5, 6, 7, "R7 accept");
        check(in_accept == 4'b0000, "R7 none accepted", 64'(in_accept), 64'h0);
        cycle(4'b0000, 0, 0, 0, 0, "R7 idle");
        check(out_valid == 4'b0000, "R7 no output valid", 64'(out_valid), 64'h0);

        // R9: four held requests to output 1, each served twice in 8 cycles.
        begin
            int cnt [NI];
            for (int i = 0; i < NI; i++) cnt[i] = 0;
            for (int t = 0; t < 8; t++) begin
                cycle(4'b1111, 1, 1, 1, 1, "R9 accept");
                for (int i = 0; i < NI; i++) cnt[i] += int'(in_accept[i]);
            end
            for (int i = 0; i < NI; i++)
                check(cnt[i] == 2, "R9 fair share", 64'(cnt[i]), 64'd2);
        end

        // R1 R4 R5 R6: sweep all valid masks and all targets 0..4.
        for (int vm = 0; vm < 16; vm++) begin
            for (int code = 0; code < 625; code++) begin
                cycle(4'(vm), code % 5, (code / 5) % 5, (code / 25) % 5,
                      (code / 125) % 5, "R1 R4 R5 accept");
                check($countones(in_accept) <= NO, "R5 row count",
                      64'($countones(in_accept)), 64'(NO));
            end
        end
        @(negedge clk);
        check_outputs();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule